// File: doc/BRIEF.md
# Run-Time Addressable Tap Shift Register

This block is a one-bit serial delay line. Every clock edge with the enable high pushes the serial input into the first stage and moves each stored bit one stage further. A 4-bit tap select picks the stage that drives the data output. The tap read is combinational, so the delay can change from one cycle to the next without disturbing the stored bits.

A separate chain output always carries the last stage. It can feed the serial input of a further unit, which gives delays longer than one unit can hold. A build-time parameter can add one output flip-flop behind the tap. That flip-flop is clocked under the same enable and adds one cycle of delay. The stages have no reset and hold unknown values until sixteen enabled shifts have filled them. Only the optional output flip-flop is reset.

Top module: `addr_tap_shreg`

## Requirements
- R1: On each rising clock edge with `ce_i` high, stage 0 takes `din_i` and every stage k>0 takes the previous value of stage k-1.
- R2: With `OUT_REG`=0, `dout_o` equals the value of stage `tap_sel_i`, which is the bit entered d+1 enabled edges ago, where d is the unsigned value of `tap_sel_i` (0 to 15).
- R3: On an edge with `ce_i` low, all stored bits are unchanged whatever `din_i` does, so for a fixed tap the outputs stay constant.
- R4: A change of `tap_sel_i` reaches `dout_o` in the same cycle, with no clock edge needed (`OUT_REG`=0).
- R5: `cascade_o` always carries stage 15, the bit entered 16 enabled edges ago, whatever the value of `tap_sel_i`.
- R6: When `cascade_o` of one unit feeds `din_i` of a second unit on the same clock and enable, the second unit's `dout_o` gives the bit entered 16+d+1 enabled edges ago.
- R7: With `OUT_REG`=1, `dout_o` is registered. On an enabled edge it captures the tap value present before that edge, for a total delay of d+2 enabled edges, and it holds while `ce_i` is low.
- R8: With `OUT_REG`=1, `rst_ni` low forces `dout_o` to 0 asynchronously. The shift stages are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous reset for the optional output flip-flop |
| ce_i | input | 1 | Shift enable |
| din_i | input | 1 | Serial data in, entering stage 0 |
| tap_sel_i | input | 4 | Stage that drives `dout_o` |
| dout_o | output | 1 | Selected stage, registered when `OUT_REG`=1 |
| cascade_o | output | 1 | Last stage, for chaining |

## Verification
The tap output and the chain output are combinational from stored state. They are due just after the enabled edge that shifts a bit in, or at once when only the tap select changes. The bench therefore samples 1 ns after each rising edge, and 1 ns after a tap change with no edge between. The registered variant is due one enabled edge later than the plain tap. A bench history of entered bits, shifted only on enabled edges, supplies every expected value. The bench checks no stage value until enough enabled shifts have filled the stages it reads.

// File: rtl/addr_tap_shreg_pkg.sv
package addr_tap_shreg_pkg;
  localparam int unsigned SEL_W_DEF = 4;

  function automatic int unsigned stage_count(input int unsigned sel_w);
    return 1 << sel_w;
  endfunction
endpackage

// File: rtl/tap_shreg_chain.sv
module tap_shreg_chain #(
  parameter int unsigned STAGES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              din_i,
  output logic [STAGES-1:0] stage_o
);
  logic [STAGES-1:0] sr_q;

  // no reset on contents: stages behave as plain storage cells
  always_ff @(posedge clk_i) begin
    if (ce_i) sr_q <= {sr_q[STAGES-2:0], din_i};
  end

  assign stage_o = sr_q;

  a_r1_stage0_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> sr_q[0] === $past(din_i));
  a_r1_stage_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> sr_q[STAGES-1:1] === $past(sr_q[STAGES-2:0]));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> sr_q === $past(sr_q));
endmodule

// File: rtl/tap_shreg_mux.sv
module tap_shreg_mux #(
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned STAGES = 1 << SEL_W
) (
  input  logic [STAGES-1:0] stage_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tap_o
);
  assign tap_o = stage_i[sel_i];
endmodule

// File: rtl/tap_shreg_out.sv
module tap_shreg_out #(
  parameter bit OUT_REG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic tap_i,
  output logic dout_o
);
  if (OUT_REG) begin : g_reg
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= 1'b0;
      else if (ce_i) q <= tap_i;
    end
    assign dout_o = q;

    a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_i |=> dout_o === $past(tap_i));
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ce_i |=> dout_o === $past(dout_o));
    a_r8_reset_clear: assert property (@(posedge clk_i)
      !rst_ni |-> dout_o == 1'b0);
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = ^{clk_i, rst_ni, ce_i};
    assign dout_o = tap_i;
  end
endmodule

// File: rtl/addr_tap_shreg.sv
module addr_tap_shreg
  import addr_tap_shreg_pkg::*;
#(
  parameter int unsigned SEL_W   = SEL_W_DEF,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned STAGES = stage_count(SEL_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             din_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic             dout_o,
  output logic             cascade_o
);
  logic [STAGES-1:0] stage;
  logic              tap;

  tap_shreg_chain #(.STAGES(STAGES)) u_chain (
    .clk_i, .rst_ni, .ce_i, .din_i, .stage_o(stage)
  );

  tap_shreg_mux #(.SEL_W(SEL_W)) u_mux (
    .stage_i(stage), .sel_i(tap_sel_i), .tap_o(tap)
  );

  tap_shreg_out #(.OUT_REG(OUT_REG)) u_out (
    .clk_i, .rst_ni, .ce_i, .tap_i(tap), .dout_o
  );

  assign cascade_o = stage[STAGES-1];

  a_r5_cascade_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> cascade_o === $past(stage[STAGES-2]));
  a_r5_cascade_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> cascade_o === $past(cascade_o));
endmodule

// File: tb/tb_addr_tap_shreg.sv
`timescale 1ns/1ps
module tb_addr_tap_shreg;
  localparam int HL = 48;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce = 1'b0, din = 1'b0;
  logic [3:0] tap = 4'd0;
  logic dout_p, casc_p, dout_c, casc_c, dout_r, casc_r;

  int n_chk = 0, n_fail = 0;
  logic hist [HL];
  logic reg_exp;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  addr_tap_shreg dut (.clk_i(clk), .rst_ni, .ce_i(ce), .din_i(din),
    .tap_sel_i(tap), .dout_o(dout_p), .cascade_o(casc_p));
  addr_tap_shreg dut_chain (.clk_i(clk), .rst_ni, .ce_i(ce), .din_i(casc_p),
    .tap_sel_i(tap), .dout_o(dout_c), .cascade_o(casc_c));
  addr_tap_shreg #(.OUT_REG(1'b1)) dut_reg (.clk_i(clk), .rst_ni, .ce_i(ce),
    .din_i(din), .tap_sel_i(tap), .dout_o(dout_r), .cascade_o(casc_r));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // drive at negedge, model the edge, sample 1 ns after posedge
  task automatic step(input logic d, input logic e, input logic [3:0] t);
    @(negedge clk);
    din = d; ce = e; tap = t;
    @(posedge clk);
    if (e) begin
      reg_exp = hist[t];
      for (int i = HL - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
    end
    #1;
  endtask

  task automatic check_all(input string tag);
    chk({"R2 ", tag}, dout_p, hist[tap]);
    chk({"R5 ", tag}, casc_p, hist[15]);
    chk({"R6 ", tag}, dout_c, hist[16 + int'(tap)]);
    chk({"R7 ", tag}, dout_r, reg_exp);
  endtask

  task automatic t_reset();
    #1;
    chk("R8 reset", dout_r, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R8 after release no ce", dout_r, 1'b0);
  endtask

  task automatic t_prime();
    for (int i = 0; i < 40; i++) step(next_bit(), 1'b1, 4'd0);
    chk("R1 stage0 loads din", dout_p, din);
    chk("R5 prime", casc_p, hist[15]);
  endtask

  task automatic t_tap_sweep();
    for (int d = 0; d < 16; d++) begin
      @(negedge clk); ce = 1'b0; tap = 4'(d); #1;
      chk("R4 same-cycle tap", dout_p, hist[d]);
      chk("R5 tap independent", casc_p, hist[15]);
    end
  endtask

  task automatic t_pattern(input int n);
    for (int i = 0; i < n; i++) begin
      step(next_bit(), 1'b1, 4'(next_bit() ? i : 15 - (i % 16)));
      check_all("pattern");
    end
  endtask

  task automatic t_hold();
    logic p, c, r;
    step(1'b1, 1'b1, 4'd5);
    p = dout_p; c = casc_p; r = dout_r;
    for (int i = 0; i < 6; i++) begin
      step(i[0], 1'b0, 4'd5);
      chk("R3 hold tap", dout_p, p);
      chk("R3 hold cascade", casc_p, c);
      chk("R7 reg holds", dout_r, r);
    end
    check_all("after hold");
  endtask

  task automatic t_ce_toggle();
    for (int i = 0; i < 24; i++) begin
      step(next_bit(), i[0], 4'(i % 16));
      check_all("ce toggle");
    end
  endtask

  task automatic t_bound_taps();
    for (int i = 0; i < 8; i++) begin
      step(next_bit(), 1'b1, i[0] ? 4'd15 : 4'd0);
      check_all("tap boundary");
    end
  endtask

  initial begin
    for (int i = 0; i < HL; i++) hist[i] = 1'b0;
    reg_exp = 1'b0;
    t_reset();
    t_prime();
    t_tap_sweep();
    t_pattern(40);
    t_hold();
    t_ce_toggle();
    t_bound_taps();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule